// File: doc/BRIEF.md
# Streaming Differentiator FIR

This block estimates the time derivative of a sampled signal. It is a 33-tap FIR filter whose taps approximate an ideal discrete-time differentiator, with a target response of jω across −π < ω < π. The taps are fixed constants: the ideal differentiator impulse response, tapered by a raised-cosine (Hanning) window to tame truncation ripple, then quantised to fixed point. In a mismatch-correction datapath the block feeds the clock-skew regressor branch. That branch needs the derivative of the corrected stream, aligned to the filter's centre sample.

One signed sample enters per clock when `in_valid` is high. The ideal taps are odd about the centre, and the centre tap is zero. The filter therefore first subtracts each mirrored pair of stored samples and multiplies the difference once, so only 16 multipliers are needed for 33 taps. Registers separate the delay line, the pair subtraction, the multiply, a grouped partial sum, and the final sum with rounding and saturation. A result therefore appears a fixed number of clocks after its input. It describes the sample 16 accepted samples earlier, which is the filter's group delay.

Top module: `deriv_fir`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and `out_deriv` are 0 in the following cycle. The sample history is cleared to zeros, and inputs presented during reset are discarded.
- R2: Each sample accepted with `in_valid` high produces exactly one `out_valid` pulse, 5 clock cycles after the cycle in which it was presented. Results appear in acceptance order.
- R3: Let x[0] be the newest accepted sample and x[i] the sample accepted i inputs earlier, with zeros before the first sample after reset. The full-precision sum is S = Σ_{k=1..16} c_k·(x[16+k] − x[16−k]). The centre sample x[16] does not contribute.
- R4: The coefficients are 12-bit signed with 11 fractional bits. Each is c_k = (−1)^k · round(2048 · 0.5·(1 + cos(πk/17)) / k) for k = 1..16, with the rounding taken on the magnitude.
- R5: The result is rounded half-up: out = floor((S + 1024) / 2048).
- R6: The rounded result saturates to the 13-bit signed range [−4096, 4095].
- R7: A cycle with `in_valid` low does not advance the sample history and produces no `out_valid` pulse. While `out_valid` is low, `out_deriv` keeps its last value.
- R8: A constant input held for at least 33 samples gives an output of exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_sample` carries a new sample this cycle |
| in_sample | input | 12 | Signed input sample |
| out_valid | output | 1 | `out_deriv` carries a new result this cycle |
| out_deriv | output | 13 | Signed derivative estimate, rounded and saturated |

## Verification
Every result is due exactly 5 clocks after its sample was presented. The bench stamps each expected item with the cycle count at the driving edge plus 5. On each falling edge the monitor compares that stamp with the current count, so an early, late or missing pulse is reported alongside a wrong value. The expected value comes from a 33-entry history held in the bench, with the coefficients recomputed from the windowed formula in real arithmetic. This history is updated only when a sample is driven, so idle gaps and mid-stream resets move the model and the design together. Between pulses the monitor also checks that the output word holds its value.

// File: rtl/deriv_fir_pkg.sv
package deriv_fir_pkg;

    localparam int SAMPLE_W        = 12;
    localparam int COEF_W          = 12;
    localparam int COEF_FRAC       = 11;
    localparam int RESULT_W        = 13;
    localparam int HALF_LEN        = 16;
    localparam int TAP_CNT         = 2 * HALF_LEN + 1;
    localparam int DIFF_W          = SAMPLE_W + 1;
    localparam int PROD_W          = DIFF_W + COEF_W;
    localparam int ACC_W           = PROD_W + $clog2(HALF_LEN) + 1;
    localparam int LANES_PER_GROUP = 4;
    localparam int PIPE_LAT        = 5;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [DIFF_W-1:0]   diff_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [PROD_W-1:0]   prod_t;
    typedef logic signed [ACC_W-1:0]    acc_t;
    typedef logic signed [RESULT_W-1:0] result_t;

    localparam result_t RES_MAX   = result_t'(2**(RESULT_W-1) - 1);
    localparam result_t RES_MIN   = {1'b1, {(RESULT_W-1){1'b0}}};
    localparam acc_t    RES_MAX_A = acc_t'(2**(RESULT_W-1) - 1);
    localparam acc_t    RES_MIN_A = acc_t'(-(2**(RESULT_W-1)));

    // Windowed differentiator taps for offsets 1..HALF_LEN (Q1.11).
    // Taps at negative offsets are the negatives of these; the centre tap is zero.
    function automatic coef_t tap_coef(input int k);
        case (k)
            1:       return -12'sd2031;
            2:       return  12'sd989;
            3:       return -12'sd632;
            4:       return  12'sd445;
            5:       return -12'sd328;
            6:       return  12'sd247;
            7:       return -12'sd186;
            8:       return  12'sd140;
            9:       return -12'sd103;
            10:      return  12'sd74;
            11:      return -12'sd52;
            12:      return  12'sd34;
            13:      return -12'sd21;
            14:      return  12'sd11;
            15:      return -12'sd5;
            16:      return  12'sd1;
            default: return '0;
        endcase
    endfunction

    // Round half up at the binary point, then clamp to the result range.
    function automatic result_t round_sat(input acc_t a);
        acc_t biased;
        acc_t scaled;
        biased = a + acc_t'(2**(COEF_FRAC-1));
        scaled = biased >>> COEF_FRAC;
        if (scaled > RES_MAX_A)      return RES_MAX;
        else if (scaled < RES_MIN_A) return RES_MIN;
        else                         return scaled[RESULT_W-1:0];
    endfunction

endpackage

// File: rtl/deriv_fir_taps.sv
module deriv_fir_taps
    import deriv_fir_pkg::*;
#(
    parameter int DEPTH = TAP_CNT
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  sample_t in_sample,
    output sample_t taps [DEPTH],
    output logic    taps_vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
            taps_vld <= 1'b0;
        end else begin
            taps_vld <= in_valid;
            if (in_valid) begin
                taps[0] <= in_sample;
                for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
            end
        end
    end

    p_history_load_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (taps[0] == $past(in_sample)));

    p_history_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(taps[0]) && $stable(taps[DEPTH-1])));

endmodule

// File: rtl/deriv_fir_fold.sv
module deriv_fir_fold
    import deriv_fir_pkg::*;
#(
    parameter int LANES = HALF_LEN
) (
    input  logic    clk,
    input  logic    rst,
    input  sample_t taps [2*LANES+1],
    input  logic    taps_vld,
    output prod_t   prod [LANES],
    output logic    prod_vld
);

    diff_t diff_q [LANES];
    logic  diff_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            diff_vld <= 1'b0;
            prod_vld <= 1'b0;
        end else begin
            diff_vld <= taps_vld;
            prod_vld <= diff_vld;
        end
    end

    // Lane j handles offset j+1: older sample minus newer sample, then one multiply.
    always_ff @(posedge clk) begin
        for (int j = 0; j < LANES; j++) begin
            diff_q[j] <= diff_t'(taps[LANES+1+j]) - diff_t'(taps[LANES-1-j]);
            prod[j]   <= prod_t'(diff_q[j]) * prod_t'(tap_coef(j + 1));
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane_chk
        p_pair_null_r8: assert property (@(posedge clk) disable iff (rst)
            (taps[LANES+1+j] == taps[LANES-1-j]) |=> (diff_q[j] == '0));
    end

endmodule

// File: rtl/deriv_fir_sum.sv
module deriv_fir_sum
    import deriv_fir_pkg::*;
#(
    parameter int LANES = HALF_LEN,
    parameter int GROUP = LANES_PER_GROUP
) (
    input  logic    clk,
    input  logic    rst,
    input  prod_t   prod [LANES],
    input  logic    prod_vld,
    output result_t result,
    output logic    result_vld
);

    localparam int   NGRP    = LANES / GROUP;
    localparam acc_t HI_EDGE = acc_t'((2**(RESULT_W-1)) * (2**COEF_FRAC) - 2**(COEF_FRAC-1));
    localparam acc_t LO_EDGE = acc_t'(-(2**(RESULT_W-1)) * (2**COEF_FRAC) - 2**(COEF_FRAC-1));

    acc_t grp_c [NGRP];
    acc_t grp_q [NGRP];
    logic grp_vld;
    acc_t total;

    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            grp_c[g] = '0;
            for (int l = 0; l < GROUP; l++) grp_c[g] = grp_c[g] + acc_t'(prod[g*GROUP+l]);
        end
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < NGRP; g++) grp_q[g] <= grp_c[g];
        if (rst) grp_vld <= 1'b0;
        else     grp_vld <= prod_vld;
    end

    always_comb begin
        total = '0;
        for (int g = 0; g < NGRP; g++) total = total + grp_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result     <= '0;
            result_vld <= 1'b0;
        end else begin
            result_vld <= grp_vld;
            if (grp_vld) result <= round_sat(total);
        end
    end

    p_clip_high_r6: assert property (@(posedge clk) disable iff (rst)
        (grp_vld && total >= HI_EDGE) |=> (result == RES_MAX));

    p_clip_low_r6: assert property (@(posedge clk) disable iff (rst)
        (grp_vld && total < LO_EDGE) |=> (result == RES_MIN));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !grp_vld |=> $stable(result));

endmodule

// File: rtl/deriv_fir.sv
module deriv_fir
    import deriv_fir_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       out_valid,
    output logic signed [RESULT_W-1:0] out_deriv
);

    sample_t taps [TAP_CNT];
    logic    taps_vld;
    prod_t   prod [HALF_LEN];
    logic    prod_vld;
    result_t result;
    logic    result_vld;

    deriv_fir_taps #(.DEPTH(TAP_CNT)) u_taps (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .taps      (taps),
        .taps_vld  (taps_vld)
    );

    deriv_fir_fold #(.LANES(HALF_LEN)) u_fold (
        .clk      (clk),
        .rst      (rst),
        .taps     (taps),
        .taps_vld (taps_vld),
        .prod     (prod),
        .prod_vld (prod_vld)
    );

    deriv_fir_sum #(.LANES(HALF_LEN), .GROUP(LANES_PER_GROUP)) u_sum (
        .clk        (clk),
        .rst        (rst),
        .prod       (prod),
        .prod_vld   (prod_vld),
        .result     (result),
        .result_vld (result_vld)
    );

    assign out_valid = result_vld;
    assign out_deriv = result;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_deriv == '0));

    p_latency_fwd_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##5 out_valid);

    p_latency_back_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 5));

endmodule

// File: tb/deriv_fir_test.sv
`timescale 1ns/1ps
module deriv_fir_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [11:0] in_sample = '0;
    logic               out_valid;
    logic signed [12:0] out_deriv;

    always #10 clk = ~clk;

    deriv_fir uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_deriv (out_deriv)
    );

    typedef struct {
        longint val;
        int     due;
        int     req;
    } exp_t;

    exp_t   sbq[$];
    longint hist[33];
    longint cf[17];
    int     cyc = 0;
    int     n_chk = 0;
    int     n_bad = 0;
    bit     mon_en = 1'b0;
    longint last_out = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input int req, input longint act, input longint expv, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    // R4: coefficients recomputed from the windowed formula in real arithmetic
    task automatic build_coefs();
        for (int k = 1; k <= 16; k++) begin
            real w;
            longint m;
            w = 0.5 * (1.0 + $cos(3.141592653589793 * k / 17.0));
            m = longint'($rtoi(2048.0 * w / k + 0.5));
            cf[k] = (k % 2 == 1) ? -m : m;
        end
    endtask

    function automatic longint model_out();
        longint acc;
        longint r;
        acc = 0;
        for (int k = 1; k <= 16; k++) acc += cf[k] * (hist[16+k] - hist[16-k]);
        r = (acc + 1024) >>> 11;       // R5 round half up
        if (r > 4095)  r = 4095;       // R6 clamp
        if (r < -4096) r = -4096;
        return r;
    endfunction

    task automatic send(input int x, input int req);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = x[11:0];
        for (int i = 32; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = longint'(x);
        sbq.push_back('{model_out(), cyc + 5, req});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        mon_en = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_sample = 12'sd321;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            // R1: quiet outputs while reset is applied
            check(out_valid == 1'b0, 1, longint'(out_valid), 0, "valid during reset");
            check(out_deriv == '0, 1, longint'(out_deriv), 0, "data during reset");
        end
        rst = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < 33; i++) hist[i] = 0;
        sbq.delete();
        last_out = 0;
        mon_en = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Scoreboard monitor: value (R3..R8 as tagged), timing (R2), idle hold (R7)
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            if (out_valid) begin
                if (sbq.size() == 0) begin
                    check(1'b0, 2, longint'(out_deriv), 0, "unexpected valid");
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(cyc == e.due, 2, longint'(cyc), longint'(e.due), "result cycle");
                    check(longint'(out_deriv) == e.val, e.req, longint'(out_deriv), e.val, "result value");
                end
            end else begin
                check(longint'(out_deriv) == last_out, 7, longint'(out_deriv), last_out, "hold while idle");
                if (sbq.size() != 0 && sbq[0].due <= cyc) begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(1'b0, 2, 0, e.val, "missing valid");
                end
            end
            last_out = longint'(out_deriv);
        end
    end

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        int pat[33];
        build_coefs();
        do_reset();                                            // R1

        // R4 / R3: impulse reveals every tap, centre contributes nothing
        send(1000, 4);
        for (int i = 0; i < 35; i++) send(0, 4);
        idle(8);

        // R5: half-LSB ties round upward
        send(1024, 5);
        for (int i = 0; i < 35; i++) send(0, 5);
        idle(8);

        // R3: ramp
        for (int i = 0; i < 40; i++) send(i * 40 - 800, 3);
        idle(8);

        // R8: held constant nulls the output once history is full
        for (int i = 0; i < 40; i++) send(700, 8);
        idle(8);
        check(last_out == 0, 8, last_out, 0, "dc output");

        // R7 / R2: irregular gaps between samples
        for (int i = 0; i < 24; i++) begin
            send(((i * 173) % 2000) - 1000, 7);
            idle(i % 3);
        end
        idle(8);

        // R6: signs matched to the taps drive the sum past both rails
        for (int p = 0; p < 33; p++) begin
            if (p == 16) pat[p] = 0;
            else begin
                int k;
                bit older;
                k = (p < 16) ? 16 - p : p - 16;
                older = (p < 16);
                pat[p] = ((cf[k] > 0) == older) ? 2047 : -2048;
            end
        end
        for (int p = 0; p < 33; p++) send(pat[p], 6);
        idle(8);
        check(last_out == 4095, 6, last_out, 4095, "upper clamp");
        for (int p = 0; p < 33; p++) send(pat[p] == 0 ? 0 : (pat[p] > 0 ? -2048 : 2047), 6);
        idle(8);
        check(last_out == -4096, 6, last_out, -4096, "lower clamp");

        // R1 / R3: reset mid-stream clears history
        for (int i = 0; i < 10; i++) send(i * 150, 3);
        idle(8);
        do_reset();
        check(last_out == 0, 1, longint'(out_deriv), 0, "data after reset");
        for (int i = 0; i < 20; i++) send(500 - i * 60, 3);
        idle(10);

        check(sbq.size() == 0, 2, longint'(sbq.size()), 0, "pending results");
        finish_run();
    end

endmodule